// File: doc/BRIEF.md
# Sample-Paced PWM Audio Output Controller

This block is a mono audio output stage mapped onto a 32-bit register port. Software writes one 16-bit two's-complement sample per sample period; the block keeps it in a holding register and, at the next sample tick, moves it into the modulator. The modulator turns the sample into a single-bit pulse-width-modulated pin. A parameterised divider derives the sample tick from the system clock. With the default divider of 10,000 clocks and an 80 MHz clock, this gives 8 kHz.

A ready flag, also driven out as an interrupt, rises at each sample tick and drops when software writes a word. If software misses a period, the modulator keeps playing the last sample. The same write word carries an update flag. When that flag is set, the write also loads the amplifier gain pin and the active-low shutdown pin. The same bit position reads back as the ready flag.

Top module: `pwm_audio_ctrl`

## Requirements
- R1: After reset, amp_shdn_n and amp_gain are 0, irq is 1, rd_data reads 0x0001_0000, and the PWM output plays mid-scale (sample 0), giving a duty of 2^(PWM_W-1) high cycles per PWM period.
- R2: The sample tick occurs exactly once every CLK_DIV clock cycles.
- R3: A write stores wr_data[15:0] in the holding register, and rd_data[15:0] shows it on the next cycle. The stored sample becomes the modulator sample at the next sample tick.
- R4: If no write occurs before a tick, the modulator keeps the previous sample, and the PWM duty is unchanged.
- R5: A write clears the ready flag. A tick with no write in the same cycle sets it. irq always equals rd_data[16].
- R6: A write with wr_data[16]=1 sets amp_gain to wr_data[20] and amp_shdn_n to wr_data[21] on the next cycle. For example, 0x0031_0000 turns the amplifier on with gain high, and 0x0001_0000 turns it off.
- R7: A write with wr_data[16]=0 leaves amp_gain and amp_shdn_n unchanged. It changes only the held sample.
- R8: Over any 2^PWM_W consecutive cycles with a constant modulator sample s, pwm_out is high for exactly D cycles, where D = ((s XOR 0x8000) >> (16-PWM_W)). So 0x7FFF gives 2^PWM_W-1 and 0x8000 gives 0.
- R9: The rd_data layout is as follows: bits 15:0 hold the held sample, bit 16 the ready flag, bit 20 amp_gain and bit 21 amp_shdn_n; all other bits read 0.
- R10: A write in the same cycle as a tick leaves the ready flag low. The new sample is held until the following tick, and the tick transfers the previously held sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write word |
| rd_data | output | 32 | Register read word |
| irq | output | 1 | Ready-for-sample interrupt |
| pwm_out | output | 1 | Pulse-width-modulated audio pin |
| amp_gain | output | 1 | Amplifier gain select |
| amp_shdn_n | output | 1 | Amplifier shutdown, active low |

## Verification
The checker checks these rules on every cycle:
- the tick spacing;
- ready being set by a tick and cleared by a write, including a write that lands on a tick;
- the side-band pins changing only on flagged writes;
- the modulator sample changing only at a tick, and only to the held value.

Only the bench scenarios can show the following:
- the PWM duty for each sample, counted over full PWM periods;
- the repeat of a stale sample;
- the reset state seen at the pins;
- the read-word layout.

// File: rtl/pwm_audio_pkg.sv
package pwm_audio_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SMP_W    = 16;
  localparam int unsigned CTRL_BIT = 16;
  localparam int unsigned GAIN_BIT = 20;
  localparam int unsigned SHDN_BIT = 21;

  typedef struct packed {
    logic shdn_n;
    logic gain;
  } amp_ctl_t;

  function automatic logic [SMP_W-1:0] to_offset(input logic [SMP_W-1:0] s);
    return {~s[SMP_W-1], s[SMP_W-2:0]};
  endfunction
endpackage

// File: rtl/sample_tick_gen.sv
module sample_tick_gen #(
  parameter int unsigned CLK_DIV = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (wrap) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = wrap;
endmodule

// File: rtl/audio_regs.sv
module audio_regs
  import pwm_audio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              tick,
  output logic [SMP_W-1:0]  active_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              ready_o,
  output amp_ctl_t          amp_o
);
  logic [SMP_W-1:0] hold_q, hold_d;
  logic [SMP_W-1:0] act_q, act_d;
  logic             rdy_q, rdy_d;
  amp_ctl_t         amp_q, amp_d;
  logic             hold_en, act_en, amp_en;
  logic             unused_bits;

  assign unused_bits = ^{wr_data[WORD_W-1:SHDN_BIT+1], wr_data[GAIN_BIT-1:CTRL_BIT+1]};

  assign hold_en = wr_en;
  assign act_en  = tick;
  assign amp_en  = wr_en && wr_data[CTRL_BIT];

  always_comb begin
    hold_d = hold_en ? wr_data[SMP_W-1:0] : hold_q;
    act_d  = act_en  ? hold_q : act_q;
    amp_d  = amp_q;
    if (amp_en) begin
      amp_d.gain   = wr_data[GAIN_BIT];
      amp_d.shdn_n = wr_data[SHDN_BIT];
    end
    rdy_d = rdy_q;
    if (wr_en)     rdy_d = 1'b0;
    else if (tick) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
      rdy_q  <= 1'b1;
      amp_q  <= '0;
    end else begin
      hold_q <= hold_d;
      act_q  <= act_d;
      rdy_q  <= rdy_d;
      amp_q  <= amp_d;
    end
  end

  always_comb begin
    rd_data_o                 = '0;
    rd_data_o[SMP_W-1:0]      = hold_q;
    rd_data_o[CTRL_BIT]       = rdy_q;
    rd_data_o[GAIN_BIT]       = amp_q.gain;
    rd_data_o[SHDN_BIT]       = amp_q.shdn_n;
  end

  assign active_o = act_q;
  assign ready_o  = rdy_q;
  assign amp_o    = amp_q;
endmodule

// File: rtl/pwm_modulator.sv
module pwm_modulator
  import pwm_audio_pkg::*;
#(
  parameter int unsigned PWM_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] sample_i,
  output logic             pwm_o
);
  logic [SMP_W-1:0] ob;
  logic [PWM_W-1:0] duty;
  logic [PWM_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;

  assign ob = to_offset(sample_i);

  generate
    if (PWM_W >= SMP_W) begin : g_full
      assign duty = PWM_W'(ob);
    end else begin : g_trunc
      logic [SMP_W-PWM_W-1:0] unused_lsbs;
      assign duty        = ob[SMP_W-1 -: PWM_W];
      assign unused_lsbs = ob[SMP_W-PWM_W-1:0];
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    out_d = (duty > cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign pwm_o = out_q;
endmodule

// File: rtl/pwm_audio_ctrl.sv
module pwm_audio_ctrl
  import pwm_audio_pkg::*;
#(
  parameter int unsigned CLK_DIV = 10000,
  parameter int unsigned PWM_W   = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        pwm_out,
  output logic        amp_gain,
  output logic        amp_shdn_n
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic             sample_tick;
  logic [SMP_W-1:0] active_sample;
  amp_ctl_t         amp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  sample_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tick_o (sample_tick)
  );

  audio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tick      (sample_tick),
    .active_o  (active_sample),
    .rd_data_o (rd_data),
    .ready_o   (irq),
    .amp_o     (amp)
  );

  pwm_modulator #(.PWM_W(PWM_W)) u_pwm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sample_i (active_sample),
    .pwm_o    (pwm_out)
  );

  assign amp_gain   = amp.gain;
  assign amp_shdn_n = amp.shdn_n;
endmodule

// File: rtl/pwm_audio_ctrl_chk.sv
module pwm_audio_ctrl_chk #(
  parameter int unsigned CLK_DIV = 10000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        irq,
  input logic        tick,
  input logic [15:0] active,
  input logic        amp_gain,
  input logic        amp_shdn_n
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) + 1 : 2;
  logic [CW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   gap_q <= '0;
    else if (tick) gap_q <= '0;
    else          gap_q <= gap_q + 1'b1;
  end

  // R2
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick == (gap_q == CW'(CLK_DIV - 1)));

  // R5
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> irq);

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !irq);

  // R6
  ctrl_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[16]) |=>
      (amp_gain == $past(wr_data[20]) && amp_shdn_n == $past(wr_data[21])));

  // R7
  amp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[16]) |=> ($stable(amp_gain) && $stable(amp_shdn_n)));

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(active));

  // R3
  transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (active == $past(rd_data[15:0])));
endmodule

bind pwm_audio_ctrl pwm_audio_ctrl_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .irq        (irq),
  .tick       (sample_tick),
  .active     (active_sample),
  .amp_gain   (amp_gain),
  .amp_shdn_n (amp_shdn_n)
);

// File: tb/tb_pwm_audio_ctrl.sv
module tb_pwm_audio_ctrl;
  localparam int unsigned CLK_DIV = 40;
  localparam int unsigned PWM_W   = 5;
  localparam int unsigned PER     = 1 << PWM_W;

  logic        clk, rst_n, wr_en;
  logic [31:0] wr_data, rd_data;
  logic        irq, pwm_out, amp_gain, amp_shdn_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic m_gain = 0, m_shdn = 0;

  pwm_audio_ctrl #(.CLK_DIV(CLK_DIV), .PWM_W(PWM_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .pwm_out(pwm_out),
    .amp_gain(amp_gain), .amp_shdn_n(amp_shdn_n)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic int duty_of(input logic [15:0] s);
    logic [15:0] ob;
    ob = s ^ 16'h8000;
    return int'(ob >> (16 - PWM_W));
  endfunction

  function automatic logic [31:0] rd_model(input logic [15:0] s, input logic rdy);
    logic [31:0] w;
    w = '0;
    w[15:0] = s;
    w[16]   = rdy;
    w[20]   = m_gain;
    w[21]   = m_shdn;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = $urandom;
    if (d[16]) begin
      m_gain = d[20];
      m_shdn = d[21];
    end
  endtask

  task automatic wait_ready();
    while (!irq) @(negedge clk);
  endtask

  task automatic measure(output int hi);
    hi = 0;
    for (int i = 0; i < int'(PER); i++) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
  endtask

  task automatic play_and_check(input string req, input logic [15:0] s);
    int hi;
    wait_ready();
    @(posedge clk);
    @(negedge clk);
    measure(hi);
    chk(req, hi, duty_of(s));
  endtask

  initial begin
    int hi, gap;
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst_n = 0; wr_en = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 shdn_n", amp_shdn_n, 0);
    chk("R1 gain", amp_gain, 0);
    chk("R1 irq", irq, 1);
    chk("R1/R9 rd_data", rd_data, 32'h0001_0000);
    measure(hi);
    chk("R1 midscale duty", hi, PER / 2);

    // R6 enable amplifier with gain, sample zero
    wait_ready();
    do_write(32'h0031_0000);
    chk("R6 gain on", amp_gain, 1);
    chk("R6 shdn_n on", amp_shdn_n, 1);
    chk("R5 irq cleared", irq, 0);

    // R2 tick spacing: measure negedges between ready rises
    wait_ready();
    do_write(32'h0000_7FFF);
    gap = 1;
    while (!irq) begin @(negedge clk); gap++; end
    chk("R2 tick period", gap, CLK_DIV);
    @(posedge clk); @(negedge clk);
    measure(hi);
    chk("R8 full-scale duty", hi, PER - 1);

    // R7 flag clear keeps side-band pins
    do_write(32'h0000_8000);
    chk("R7 gain held", amp_gain, 1);
    chk("R7 shdn_n held", amp_shdn_n, 1);
    chk("R3 held sample readback", rd_data, rd_model(16'h8000, 1'b0));
    play_and_check("R8 min duty", 16'h8000);

    // R4 stale sample repeats over later periods
    repeat (CLK_DIV) @(negedge clk);
    measure(hi);
    chk("R4 repeated duty", hi, 0);
    chk("R5 irq mirror", {31'b0, irq}, {31'b0, rd_data[16]});

    // R10 write landing on the tick edge
    wait_ready();
    do_write(32'h0000_4000);        // tick T0 just seen; this write at T0+1
    wait_ready();                   // at negedge just after tick T1
    repeat (CLK_DIV - 1) @(negedge clk);
    do_write(32'h0000_C000);        // captured on tick T2
    chk("R10 ready stays low", irq, 0);
    measure(hi);
    chk("R10 old sample transferred", hi, duty_of(16'h4000));
    play_and_check("R10 late sample at next tick", 16'hC000);

    // R6 shutdown write
    do_write(32'h0001_0000);
    chk("R6 gain off", amp_gain, 0);
    chk("R6 shdn_n off", amp_shdn_n, 0);

    // random sweep
    for (int k = 0; k < 16; k++) begin
      v = $urandom;
      wait_ready();
      do_write(v);
      chk("R9 random readback", rd_data, rd_model(v[15:0], 1'b0));
      chk("R6/R7 random gain", amp_gain, m_gain);
      chk("R6/R7 random shdn_n", amp_shdn_n, m_shdn);
      play_and_check("R3/R8 random duty", v[15:0]);
      chk("R5 random ready", rd_data[16], 1);
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule